// File: doc/BRIEF.md
# Double-Rate Sample Receiver with Clock-Crossing Pair Buffer

This block receives a 16-bit sample bus that carries two samples in every period of a source-side data clock. The sample held during the high phase of that clock is latched on its falling edge and is labelled A. The sample held during the low phase is latched on the next rising edge and is labelled B. Each A/B pair is written into an eight-entry pair buffer in the data-clock domain. The buffer is read in the converter clock domain, which runs at twice the data-clock rate. The read side emits A and then B, one sample per converter cycle, as a plain stream of 16-bit offset-binary codes.

A single alignment input, generated in the data-clock domain, does two jobs. Each 0-to-1 transition restarts both buffer pointers. The level then enables the output: while the input is low, the output holds the mid-scale code. A static control input mirrors the order of the bus bits before capture. This suits a board whose bus routing is reversed. A sticky error flag reports a buffer underflow or overflow, and it is cleared by the next alignment edge.

Top module: `dac_rx_ddr_fifo`

## Requirements
- R1: The bus value present while dclk_i is high is captured on its falling edge as sample A. The value present while dclk_i is low is captured on the next rising edge as sample B. The output gives A of a pair in one converter cycle and B of the same pair in the following cycle, and successive pairs follow with no gap.
- R2: The buffer holds DEPTH=8 A/B pairs. The write pointer crosses to the converter domain as a Gray code, and between realignments it changes by at most one bit per write. While running, a synchronised occupancy above 8 pairs sets err_o.
- R3: On a rising data-clock edge where sync_i is 1 and was 0 at the previous edge, the pair completed at that edge is stored in entry 0 and the next write goes to entry 1. After sync_i passes through a two-flop synchroniser, its rise returns the read pointer to entry 0.
- R4: After a realignment, reading starts only when SETTLE=8 converter cycles have passed and the synchronised write pointer leads the read pointer by at least 4 pairs (half the depth). The first sample out is A of the pair from R3, and the stream then stays contiguous.
- R5: While the synchronised sync_i is 0, and during the start-up wait of R4, sample_o carries the mid-scale code 0x8000 from the next converter cycle.
- R6: With rev_i=1, bus bit i is used as sample bit 15-i before capture. With rev_i=0 the bits pass in order.
- R7: Samples are offset binary. The extreme codes 0x0000 and 0xFFFF pass through unchanged.
- R8: While running, a read with a synchronised occupancy of 0 sets err_o. err_o stays 1 until the synchronised rise of sync_i, which clears it in the next converter cycle.
- R9: After reset, sample_o is 0x8000 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk_i | input | 1 | Source data clock; one sample per edge |
| cclk_i | input | 1 | Converter clock, twice the data-clock rate |
| rst_ni | input | 1 | Active-low synchronous reset for both domains |
| bus_i | input | 16 | Double-rate sample bus |
| sync_i | input | 1 | Alignment edge and output enable level (data-clock domain) |
| rev_i | input | 1 | Mirror the bus bit order when 1 |
| sample_o | output | 16 | Offset-binary output sample stream |
| err_o | output | 1 | Sticky underflow/overflow flag |

## Verification
On every clock, the assertions check four things. The write-pointer code that crosses domains moves by at most one bit between realignments. A data-clock alignment edge puts the next write at entry 1. A low synchronised enable gives mid-scale on the next cycle. The error flag holds until a synchronised rise and then clears. Only the directed scenarios can show the rest: which pair leads the stream after an alignment edge and that the A/B order and continuity follow from it, the mirrored bus mapping, the extreme codes, and that a stalled or sped-up data clock actually raises the flag.

// File: rtl/dac_rx_pkg.sv
`timescale 1ns/1ps
package dac_rx_pkg;
    localparam int SMP_W = 16;
    typedef logic [SMP_W-1:0] smp_t;
    typedef struct packed {
        smp_t a;
        smp_t b;
    } pair_t;
    localparam smp_t MID_CODE = smp_t'(1) << (SMP_W - 1);
endpackage

// File: rtl/dac_rx_cdc_sync.sv
`timescale 1ns/1ps
module dac_rx_cdc_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.s2;
endmodule

// File: rtl/dac_rx_ddr_capture.sv
`timescale 1ns/1ps
module dac_rx_ddr_capture
    import dac_rx_pkg::*;
(
    input  logic  dclk_i,
    input  logic  rst_ni,
    input  logic  rev_i,
    input  smp_t  bus_i,
    output pair_t pair_o
);
    smp_t mirrored, ordered;

    for (genvar i = 0; i < SMP_W; i++) begin : g_mirror
        assign mirrored[i] = bus_i[SMP_W-1-i];
    end

    assign ordered = rev_i ? mirrored : bus_i;

    smp_t a_d, a_q;

    always_comb a_d = ordered;

    // high-phase sample is latched as the clock falls
    always_ff @(negedge dclk_i) begin
        if (!rst_ni) a_q <= '0;
        else         a_q <= a_d;
    end

    // low-phase sample is taken directly at the rising edge by the writer
    assign pair_o = '{a: a_q, b: ordered};
endmodule

// File: rtl/dac_rx_wr_side.sv
`timescale 1ns/1ps
module dac_rx_wr_side
    import dac_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          dclk_i,
    input  logic          rst_ni,
    input  logic          sync_i,
    input  pair_t         pair_i,
    input  logic [AW-1:0] raddr_i,
    output pair_t         rdata_o,
    output logic [PW-1:0] wgray_o,
    output logic [PW-1:0] wptr_o
);
    typedef struct packed {
        logic          sync;
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
    } wst_t;

    wst_t          w_d, w_q;
    logic [AW-1:0] waddr;
    pair_t         mem_q [DEPTH];

    always_comb begin
        w_d      = w_q;
        w_d.sync = sync_i;
        if (sync_i && !w_q.sync) begin
            waddr   = '0;
            w_d.ptr = PW'(1);
        end else begin
            waddr   = w_q.ptr[AW-1:0];
            w_d.ptr = w_q.ptr + PW'(1);
        end
        w_d.gray = w_d.ptr ^ (w_d.ptr >> 1);
    end

    always_ff @(posedge dclk_i) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge dclk_i) begin
        mem_q[waddr] <= pair_i;
    end

    assign rdata_o = mem_q[raddr_i];
    assign wgray_o = w_q.gray;
    assign wptr_o  = w_q.ptr;
endmodule

// File: rtl/dac_rx_rd_side.sv
`timescale 1ns/1ps
module dac_rx_rd_side
    import dac_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SETTLE = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int HALF = DEPTH / 2,
    localparam int CW   = $clog2(SETTLE + 1)
) (
    input  logic          cclk_i,
    input  logic          rst_ni,
    input  logic          sync_s_i,
    input  logic [PW-1:0] wgray_s_i,
    input  pair_t         rdata_i,
    output logic [AW-1:0] raddr_o,
    output smp_t          sample_o,
    output logic          err_o
);
    typedef struct packed {
        logic          sync;
        logic          run;
        logic          ph;
        logic [PW-1:0] ptr;
        logic [CW-1:0] settle;
        smp_t          hold;
        smp_t          out;
        logic          err;
    } rst_t;

    rst_t          r_d, r_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] occ;

    always_comb begin
        wbin[PW-1] = wgray_s_i[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s_i[i];
        end
    end

    assign occ = wbin - r_q.ptr;

    always_comb begin
        r_d      = r_q;
        r_d.sync = sync_s_i;
        if (!sync_s_i) begin
            r_d.run    = 1'b0;
            r_d.ph     = 1'b0;
            r_d.settle = '0;
            r_d.out    = MID_CODE;
        end else if (!r_q.sync) begin
            r_d.ptr    = '0;
            r_d.ph     = 1'b0;
            r_d.run    = 1'b0;
            r_d.settle = CW'(SETTLE);
            r_d.err    = 1'b0;
            r_d.out    = MID_CODE;
        end else if (!r_q.run) begin
            r_d.out = MID_CODE;
            if (r_q.settle != '0)          r_d.settle = r_q.settle - CW'(1);
            else if (occ >= PW'(HALF))     r_d.run    = 1'b1;
        end else begin
            if (occ > PW'(DEPTH)) r_d.err = 1'b1;
            if (!r_q.ph) begin
                if (occ == '0) r_d.err = 1'b1;
                r_d.out  = rdata_i.a;
                r_d.hold = rdata_i.b;
                r_d.ptr  = r_q.ptr + PW'(1);
                r_d.ph   = 1'b1;
            end else begin
                r_d.out = r_q.hold;
                r_d.ph  = 1'b0;
            end
        end
    end

    always_ff @(posedge cclk_i) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.out <= MID_CODE;
        end else begin
            r_q <= r_d;
        end
    end

    assign raddr_o  = r_q.ptr[AW-1:0];
    assign sample_o = r_q.out;
    assign err_o    = r_q.err;
endmodule

// File: rtl/dac_rx_ddr_fifo.sv
`timescale 1ns/1ps
module dac_rx_ddr_fifo
    import dac_rx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SETTLE = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic        dclk_i,
    input  logic        cclk_i,
    input  logic        rst_ni,
    input  logic [15:0] bus_i,
    input  logic        sync_i,
    input  logic        rev_i,
    output logic [15:0] sample_o,
    output logic        err_o
);
    pair_t         pair;
    pair_t         rdata;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray, wptr, wgray_s;
    logic          sync_s;

    dac_rx_ddr_capture u_cap (
        .dclk_i (dclk_i),
        .rst_ni (rst_ni),
        .rev_i  (rev_i),
        .bus_i  (bus_i),
        .pair_o (pair)
    );

    dac_rx_wr_side #(.DEPTH(DEPTH)) u_wr (
        .dclk_i  (dclk_i),
        .rst_ni  (rst_ni),
        .sync_i  (sync_i),
        .pair_i  (pair),
        .raddr_i (raddr),
        .rdata_o (rdata),
        .wgray_o (wgray),
        .wptr_o  (wptr)
    );

    dac_rx_cdc_sync #(.W(PW)) u_sync_ptr (
        .clk_i  (cclk_i),
        .rst_ni (rst_ni),
        .d_i    (wgray),
        .q_o    (wgray_s)
    );

    dac_rx_cdc_sync #(.W(1)) u_sync_en (
        .clk_i  (cclk_i),
        .rst_ni (rst_ni),
        .d_i    (sync_i),
        .q_o    (sync_s)
    );

    dac_rx_rd_side #(.DEPTH(DEPTH), .SETTLE(SETTLE)) u_rd (
        .cclk_i    (cclk_i),
        .rst_ni    (rst_ni),
        .sync_s_i  (sync_s),
        .wgray_s_i (wgray_s),
        .rdata_i   (rdata),
        .raddr_o   (raddr),
        .sample_o  (sample_o),
        .err_o     (err_o)
    );
endmodule

// File: rtl/dac_rx_ddr_fifo_chk.sv
`timescale 1ns/1ps
module dac_rx_ddr_fifo_chk #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input logic          dclk_i,
    input logic          cclk_i,
    input logic          rst_ni,
    input logic          sync_i,
    input logic          sync_s,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] wptr,
    input logic [15:0]   sample_o,
    input logic          err_o
);
    // R2: crossing code moves one bit at a time between realignments
    p_gray_step_r2: assert property (@(posedge dclk_i) disable iff (!rst_ni)
        !(sync_i && !$past(sync_i)) |=> ($countones(wgray ^ $past(wgray)) <= 1));

    // R3: after an alignment edge the next write goes to entry 1
    p_wr_realign_r3: assert property (@(posedge dclk_i) disable iff (!rst_ni)
        (sync_i && !$past(sync_i)) |=> (wptr == PW'(1)));

    // R5: disabled output is mid-scale on the next cycle
    p_mid_when_off_r5: assert property (@(posedge cclk_i) disable iff (!rst_ni)
        !sync_s |=> (sample_o == 16'h8000));

    // R8: flag is sticky until a synchronised rise
    p_err_hold_r8: assert property (@(posedge cclk_i) disable iff (!rst_ni)
        (err_o && !(sync_s && !$past(sync_s))) |=> err_o);

    // R8: a synchronised rise clears the flag
    p_err_clear_r8: assert property (@(posedge cclk_i) disable iff (!rst_ni)
        (sync_s && !$past(sync_s)) |=> !err_o);
endmodule

bind dac_rx_ddr_fifo dac_rx_ddr_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .dclk_i   (dclk_i),
    .cclk_i   (cclk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .sync_s   (sync_s),
    .wgray    (wgray),
    .wptr     (wptr),
    .sample_o (sample_o),
    .err_o    (err_o)
);

// File: tb/tb_dac_rx_ddr_fifo.sv
`timescale 1ns/1ps
module tb_dac_rx_ddr_fifo;
    logic        cclk = 1'b0;
    logic        dclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        rev = 1'b0;
    logic [15:0] bus = '0;
    logic [15:0] sample;
    logic        err;

    int total = 0;
    int bad = 0;
    int dhalf = 5;
    bit dclk_en = 1'b1;
    bit sync_req = 1'b0;
    int mode = 0;
    int pidx = 0;
    int k0 = 0;
    logic [15:0] sent [4096];

    dac_rx_ddr_fifo dut (
        .dclk_i   (dclk),
        .cclk_i   (cclk),
        .rst_ni   (rst_n),
        .bus_i    (bus),
        .sync_i   (sync),
        .rev_i    (rev),
        .sample_o (sample),
        .err_o    (err)
    );

    // 200 MHz converter clock
    initial forever #2.5 cclk = ~cclk;

    initial begin
        #1;
        forever begin
            #(dhalf);
            if (dclk_en) dclk = ~dclk;
        end
    end

    function automatic logic [15:0] flip16(logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic logic [15:0] pattern(int n);
        case (mode)
            1:       return (n % 2 == 0) ? 16'h0000 : 16'hFFFF;
            2:       return 16'($urandom()) & 16'h7FFF;
            default: return 16'h1000 + 16'(n & 16'h3FFF);
        endcase
    endfunction

    // source: A during high phase, B during low phase
    initial begin
        logic [15:0] v;
        forever begin
            @(posedge dclk);
            #1;
            if (sync_req && !sync) k0 = pidx;
            sync = sync_req;
            v = pattern(2 * pidx);
            sent[(2 * pidx) % 4096] = v;
            bus = rev ? flip16(v) : v;
            @(negedge dclk);
            #1;
            v = pattern(2 * pidx + 1);
            sent[(2 * pidx + 1) % 4096] = v;
            bus = rev ? flip16(v) : v;
            pidx++;
        end
    end

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drop_sync();
        sync_req = 1'b0;
        repeat (4) @(posedge dclk);
        #2;
    endtask

    task automatic raise_sync();
        sync_req = 1'b1;
        repeat (2) @(posedge dclk);
        #2;
    endtask

    // waits for the stream, checks the lead sample and n following samples
    task automatic expect_stream(string req_first, int n);
        int waitc = 0;
        int mism = 0;
        logic [15:0] fa = '0, fe = '0;
        @(negedge cclk);
        while (sample == 16'h8000 && waitc < 400) begin
            @(negedge cclk);
            waitc++;
        end
        chk(sample == sent[(2 * k0) % 4096], req_first, sample, sent[(2 * k0) % 4096]);
        for (int j = 1; j < n; j++) begin
            @(negedge cclk);
            if (sample !== sent[(2 * k0 + j) % 4096]) begin
                if (mism == 0) begin
                    fa = sample;
                    fe = sent[(2 * k0 + j) % 4096];
                end
                mism++;
            end
        end
        chk(mism == 0, "R1 contiguous A/B stream", fa, fe);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge cclk);
        chk(sample == 16'h8000, "R9 reset sample", sample, 16'h8000);
        chk(err == 1'b0, "R9 reset err", 16'(err), 16'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge cclk);
        chk(sample == 16'h8000, "R5 idle while sync low", sample, 16'h8000);
    endtask

    task automatic t_stream();
        mode = 0;
        raise_sync();
        expect_stream("R4 first sample after realign", 40);
        chk(err == 1'b0, "R8 no error at equal rates", 16'(err), 16'h0);
    endtask

    task automatic t_disable();
        drop_sync();
        repeat (6) @(negedge cclk);
        chk(sample == 16'h8000, "R5 mid-scale when disabled", sample, 16'h8000);
        raise_sync();
        expect_stream("R3 second realignment lead pair", 30);
    endtask

    task automatic t_reverse();
        drop_sync();
        mode = 2;
        rev = 1'b1;
        raise_sync();
        expect_stream("R6 mirrored bus first sample", 40);
        drop_sync();
        rev = 1'b0;
        raise_sync();
        expect_stream("R6 straight bus first sample", 20);
    endtask

    task automatic t_extremes();
        drop_sync();
        mode = 1;
        raise_sync();
        expect_stream("R7 code 0x0000 first", 24);
        @(negedge cclk);
        chk(sample == 16'h0000 || sample == 16'hFFFF, "R7 extreme code", sample, 16'hFFFF);
    endtask

    task automatic t_underflow();
        drop_sync();
        mode = 0;
        raise_sync();
        expect_stream("R4 lead before stall", 10);
        dclk_en = 1'b0;
        repeat (100) @(negedge cclk);
        chk(err == 1'b1, "R8 underflow flag", 16'(err), 16'h1);
        dclk_en = 1'b1;
        drop_sync();
        repeat (10) @(negedge cclk);
        chk(err == 1'b1, "R8 flag sticky while disabled", 16'(err), 16'h1);
        raise_sync();
        expect_stream("R4 lead after stall", 20);
        chk(err == 1'b0, "R8 flag cleared by realign", 16'(err), 16'h0);
    endtask

    task automatic t_overflow();
        dhalf = 3;
        repeat (300) @(negedge cclk);
        chk(err == 1'b1, "R2 overflow past 8 pairs", 16'(err), 16'h1);
        dhalf = 5;
        drop_sync();
        raise_sync();
        expect_stream("R4 lead after overflow", 20);
        chk(err == 1'b0, "R2 flag clear after realign", 16'(err), 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge cclk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_disable();
        t_reverse();
        t_extremes();
        t_underflow();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule